// File: doc/BRIEF.md
# Processor Status Latch and Bus Command Decoder

This block sits next to an 8-bit processor whose data bus carries a status byte during the first part of every machine cycle. The processor marks that moment with a sync strobe. The block registers the byte on the strobe and holds it until the next strobe. It combines the held byte with the processor's live read and write strobes to produce five separate active-low bus commands: memory read, memory write, port read, port write and interrupt acknowledge. It also provides three active-high indicators, for stack access, halt and opcode fetch.

When the processor signals that it has handed the buses to a DMA master, the block drives every command inactive. A mode input folds port cycles onto the memory command lines, for systems that decode ports as memory locations. Processors of this kind copy the 8-bit port number onto both halves of the address bus, so those systems need no extra address logic.

Top module: `cpu_status_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the held status becomes 0x00. After that edge all five commands are high and all three indicators are low.
- R2: When `sync_stb` is high at a rising edge, the byte on `data_in` is captured. It appears on `status_q` from that edge onward.
- R3: When `sync_stb` is low at a rising edge, `status_q` keeps its value, whatever `data_in` carries.
- R4: `mem_rd_n` is low exactly when `rd_stb` is high and held status bit 7 (memory read) is set. Outside mapped mode this is the only way it goes low.
- R5: `port_rd_n` is low exactly when `rd_stb` is high, held bit 6 (port input) is set and mapped mode is off.
- R6: `int_ack_n` is low exactly when `rd_stb` is high and held bit 0 (interrupt fetch) is set.
- R7: When `wr_n` is low, the write goes to `port_wr_n` if held bit 4 (port output) is set, and to `mem_wr_n` if it is clear. The two write commands are never low together.
- R8: `stack_ind`, `halt_ind` and `fetch_ind` follow held status bits 2, 3 and 5 respectively.
- R9: While `dma_ack` is high, all five commands are high, whatever the strobes and status are.
- R10: While `io_as_mem` is high, port reads also drive `mem_rd_n` low, port writes drive `mem_wr_n` low, and `port_rd_n`/`port_wr_n` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_stb | input | 1 | Status-phase strobe from the processor |
| data_in | input | 8 | Processor data bus (status byte during sync) |
| rd_stb | input | 1 | Read / data-in strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| dma_ack | input | 1 | Processor has released the buses |
| io_as_mem | input | 1 | Route port cycles onto memory commands |
| status_q | output | 8 | Held status byte |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| port_rd_n | output | 1 | Port read command, active low |
| port_wr_n | output | 1 | Port write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge command, active low |
| stack_ind | output | 1 | Stack access indicator |
| halt_ind | output | 1 | Halt acknowledge indicator |
| fetch_ind | output | 1 | Opcode fetch indicator |

## Verification
Two events can land in the same cycle. One is a new sync strobe arriving while a read or write strobe is still active; the other is a DMA release coinciding with a command-producing status. The bench drives random combinations of sync, strobes, DMA and mode on every cycle. Its reference model updates the status only at the edge that sampled sync, so a command in a sync cycle must decode from the previous byte. Any command low while DMA is high is judged a failure, whatever the status.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

    localparam int STAT_W = 8;

    // Field order is fixed: bit 7 first, bit 0 last
    typedef struct packed {
        logic mem_read;   // bit 7
        logic port_in;    // bit 6
        logic opc_fetch;  // bit 5
        logic port_out;   // bit 4
        logic halt_ack;   // bit 3
        logic stack_acc;  // bit 2
        logic rd_cycle;   // bit 1
        logic int_fetch;  // bit 0
    } status_t;

    typedef struct packed {
        logic mrd;
        logic mwr;
        logic prd;
        logic pwr;
        logic iak;
    } cmd_t;   // active high internally

    localparam cmd_t CMD_IDLE = '0;

    function automatic cmd_t decode_cmd(status_t s, logic rd, logic wr_act,
                                        logic released, logic fold_io);
        cmd_t c;
        c     = CMD_IDLE;
        c.iak = rd & s.int_fetch;
        c.mrd = rd & (s.mem_read | (fold_io & s.port_in));
        c.prd = rd & s.port_in & ~fold_io;
        c.mwr = wr_act & (~s.port_out | fold_io);
        c.pwr = wr_act & s.port_out & ~fold_io;
        if (released)
            c = CMD_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/status_hold.sv
module status_hold
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [STAT_W-1:0] bus,
    output status_t           held
);
    status_t held_r;

    always_ff @(posedge clk) begin
        if (rst)
            held_r <= '0;
        else if (capture)
            held_r <= status_t'(bus);
    end

    assign held = held_r;
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import cpu_status_pkg::*;
(
    input  status_t held,
    input  logic    rd_stb,
    input  logic    wr_n,
    input  logic    dma_ack,
    input  logic    io_as_mem,
    output cmd_t    cmd
);
    always_comb begin
        cmd = decode_cmd(held, rd_stb, ~wr_n, dma_ack, io_as_mem);
    end
endmodule

// File: rtl/cpu_status_decoder.sv
module cpu_status_decoder
    import cpu_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_stb,
    input  logic [STAT_W-1:0] data_in,
    input  logic              rd_stb,
    input  logic              wr_n,
    input  logic              dma_ack,
    input  logic              io_as_mem,
    output logic [STAT_W-1:0] status_q,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              port_rd_n,
    output logic              port_wr_n,
    output logic              int_ack_n,
    output logic              stack_ind,
    output logic              halt_ind,
    output logic              fetch_ind
);
    status_t held;
    cmd_t    cmd;

    status_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (sync_stb),
        .bus     (data_in),
        .held    (held)
    );

    cmd_decode u_dec (
        .held      (held),
        .rd_stb    (rd_stb),
        .wr_n      (wr_n),
        .dma_ack   (dma_ack),
        .io_as_mem (io_as_mem),
        .cmd       (cmd)
    );

    assign status_q  = held;
    assign mem_rd_n  = ~cmd.mrd;
    assign mem_wr_n  = ~cmd.mwr;
    assign port_rd_n = ~cmd.prd;
    assign port_wr_n = ~cmd.pwr;
    assign int_ack_n = ~cmd.iak;
    assign stack_ind = held.stack_acc;
    assign halt_ind  = held.halt_ack;
    assign fetch_ind = held.opc_fetch;
endmodule

// File: rtl/cpu_status_decoder_chk.sv
module cpu_status_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_stb,
    input logic [7:0] data_in,
    input logic       dma_ack,
    input logic       io_as_mem,
    input logic [7:0] status_q,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       port_rd_n,
    input logic       port_wr_n,
    input logic       int_ack_n
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status_q == 8'h00));

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        sync_stb |=> (status_q == $past(data_in)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sync_stb |=> $stable(status_q));

    p_wr_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_n || port_wr_n));

    p_dma_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        dma_ack |-> (mem_rd_n && mem_wr_n && port_rd_n && port_wr_n && int_ack_n));

    p_fold_ports_r10: assert property (@(posedge clk) disable iff (rst)
        io_as_mem |-> (port_rd_n && port_wr_n));
endmodule

bind cpu_status_decoder cpu_status_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_stb  (sync_stb),
    .data_in   (data_in),
    .dma_ack   (dma_ack),
    .io_as_mem (io_as_mem),
    .status_q  (status_q),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .port_rd_n (port_rd_n),
    .port_wr_n (port_wr_n),
    .int_ack_n (int_ack_n)
);

// File: tb/tb_cpu_status_decoder.sv
module tb_cpu_status_decoder;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst, sync_stb, rd_stb, wr_n, dma_ack, io_as_mem;
    logic [7:0] data_in;
    logic [7:0] status_q;
    logic       mem_rd_n, mem_wr_n, port_rd_n, port_wr_n, int_ack_n;
    logic       stack_ind, halt_ind, fetch_ind;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] model = 8'h00;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cpu_status_decoder dut (
        .clk(clk), .rst(rst), .sync_stb(sync_stb), .data_in(data_in),
        .rd_stb(rd_stb), .wr_n(wr_n), .dma_ack(dma_ack), .io_as_mem(io_as_mem),
        .status_q(status_q), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .port_rd_n(port_rd_n), .port_wr_n(port_wr_n), .int_ack_n(int_ack_n),
        .stack_ind(stack_ind), .halt_ind(halt_ind), .fetch_ind(fetch_ind)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected commands, active low, from the requirement text
    function automatic logic e_mrd(logic [7:0] s);
        return !(!dma_ack && rd_stb && (s[7] || (io_as_mem && s[6])));
    endfunction
    function automatic logic e_prd(logic [7:0] s);
        return !(!dma_ack && rd_stb && s[6] && !io_as_mem);
    endfunction
    function automatic logic e_iak(logic [7:0] s);
        return !(!dma_ack && rd_stb && s[0]);
    endfunction
    function automatic logic e_mwr(logic [7:0] s);
        return !(!dma_ack && !wr_n && (!s[4] || io_as_mem));
    endfunction
    function automatic logic e_pwr(logic [7:0] s);
        return !(!dma_ack && !wr_n && s[4] && !io_as_mem);
    endfunction

    task automatic check_all();
        chk("R2/R3 status", status_q, model);
        chk("R4 mem_rd_n", {7'd0, mem_rd_n}, {7'd0, e_mrd(model)});
        chk("R5 port_rd_n", {7'd0, port_rd_n}, {7'd0, e_prd(model)});
        chk("R6 int_ack_n", {7'd0, int_ack_n}, {7'd0, e_iak(model)});
        chk("R7 mem_wr_n", {7'd0, mem_wr_n}, {7'd0, e_mwr(model)});
        chk("R7 port_wr_n", {7'd0, port_wr_n}, {7'd0, e_pwr(model)});
        chk("R8 indicators", {5'd0, stack_ind, halt_ind, fetch_ind},
            {5'd0, model[2], model[3], model[5]});
    endtask

    // Drive at negedge, check combinational outputs, then pass the edge
    task automatic cyc(input logic r, input logic s, input logic [7:0] d,
                       input logic rd, input logic w_n, input logic dm, input logic m);
        @(negedge clk);
        rst = r; sync_stb = s; data_in = d; rd_stb = rd; wr_n = w_n;
        dma_ack = dm; io_as_mem = m;
        #1;
        check_all();
        @(posedge clk);
        if (r) model = 8'h00;
        else if (s) model = d;
    endtask

    initial begin
        rst = 1; sync_stb = 0; data_in = 8'h00; rd_stb = 0; wr_n = 1;
        dma_ack = 0; io_as_mem = 0;
        void'($urandom(32'd4242));
        @(posedge clk);
        cyc(1, 1, 8'hFF, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 0, 1, 0, 0);
        // R1: reset state
        chk("R1 status after reset", status_q, 8'h00);
        chk("R1 commands idle", {3'd0, mem_rd_n, mem_wr_n, port_rd_n, port_wr_n, int_ack_n}, 8'h1F);
        // R2/R4/R8: opcode fetch from memory (bits 7,5,1)
        cyc(0, 1, 8'hA2, 0, 1, 0, 0);
        cyc(0, 0, 8'h55, 1, 1, 0, 0);
        chk("R4 fetch read low", {7'd0, mem_rd_n}, 8'h00);
        chk("R8 fetch_ind", {7'd0, fetch_ind}, 8'h01);
        // R3: bus ignored without sync
        cyc(0, 0, 8'h11, 0, 1, 0, 0);
        chk("R3 hold", status_q, 8'hA2);
        // R7: port output (bit 4) then stack write (bit 2)
        cyc(0, 1, 8'h10, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 0, 0, 0, 0);
        chk("R7 port write low", {7'd0, port_wr_n}, 8'h00);
        cyc(0, 1, 8'h04, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 0, 0, 0, 0);
        chk("R7 mem write low", {7'd0, mem_wr_n}, 8'h00);
        chk("R8 stack_ind", {7'd0, stack_ind}, 8'h01);
        // R6: interrupt fetch, R9: DMA in the same cycle
        cyc(0, 1, 8'h23, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 1, 1, 0, 0);
        chk("R6 int_ack low", {7'd0, int_ack_n}, 8'h00);
        cyc(0, 0, 8'h00, 1, 0, 1, 0);
        chk("R9 all idle under dma", {3'd0, mem_rd_n, mem_wr_n, port_rd_n, port_wr_n, int_ack_n}, 8'h1F);
        // R5 and R10: port input, normal then folded
        cyc(0, 1, 8'h42, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 1, 1, 0, 0);
        chk("R5 port read low", {7'd0, port_rd_n}, 8'h00);
        cyc(0, 0, 8'h00, 1, 1, 0, 1);
        chk("R10 folded read", {6'd0, mem_rd_n, port_rd_n}, 8'h01);
        // R8: halt
        cyc(0, 1, 8'h8A, 0, 1, 0, 0);
        cyc(0, 0, 8'h00, 0, 1, 0, 0);
        chk("R8 halt_ind", {7'd0, halt_ind}, 8'h01);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 50) == 0, $urandom % 3 == 0, 8'($urandom),
                1'($urandom), 1'($urandom), ($urandom % 6) == 0, ($urandom % 4) == 0);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule